// File: doc/BRIEF.md
# Root Clock Generator with Fractional M/N Stage

This block derives a clock-enable pulse train from one of several source clock enables that run in the same clock domain. A source is chosen, its ticks are thinned by an integer pre-divider, and an optional M/N accumulator stage then passes M of every N pre-divided ticks. The result is an average rate of (source rate / divide) * M / N, and it drives a single registered enable output.

Software programs the block through a small synchronous register bus. Every setting is held in a staged copy and has no effect until software requests an update. The hardware then moves all staged values into the live datapath in one step, at a pre-divider terminal count. At that moment the divide counter and the accumulator restart from zero, so no partial pulse is produced. Software polls the update bit until it reads back zero.

Top module: `root_clk_gen`

## Requirements
- R1: Registers are at word addresses 0 (command, bit 0 only), 1 (configuration, bits [13:0]), 2 (M), 3 (inverted N term) and 4 (inverted duty term). M, N and D each hold 16 bits. Bits above a register's width read back as zero, and reads of addresses 5 to 7 return zero.
- R2: Synchronous reset clears all staged and live settings to zero, which means pre-divider bypass and M/N bypass. It also clears the pending update and drives the output enable low.
- R3: Configuration bits [10:8] select which source enable bit feeds the divider. A value with no source behind it selects a constant low.
- R4: Configuration bits [4:0] form the pre-divider field f. f = 0 passes every selected tick. Otherwise one pulse is produced every (f+1)/2 selected ticks, using integer division, so an integer ratio d is written as 2d-1.
- R5: The M/N stage is active when the N register is nonzero and configuration bits [13:12] equal 2. The effective N is computed as (bitwise NOT of the N register) + M, in 16 bits. Starting from a restart, k pre-divided ticks yield floor(k*M/N) output pulses.
- R6: If the N register is nonzero but bits [13:12] hold a value other than 2, the M/N stage is bypassed. Every pre-divided tick then reaches the output.
- R7: Writes to the configuration, M, N and D registers change only the staged copy. Output behaviour is unchanged until an update is committed.
- R8: Writing 1 to command bit 0 marks an update pending, and the bit reads back 1 until the commit. Writing 0 to that bit does not cancel a pending update.
- R9: A pending update commits only in a cycle where the live pre-divider reaches its terminal count on a selected tick. The commit loads all staged values, clears the pending bit and restarts the divide counter and accumulator.
- R10: Staged writes made while an update is pending are included in that commit, with the last written value taking effect. An update request written in the same cycle as a commit stays pending for the next terminal count.
- R11: The output enable is registered and rises in the cycle after the selected tick that produced it. When the live ratio is greater than one, it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| srcEn | input | NUM_SRC | Source clock enables, one per source |
| regAddr | input | 3 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational from address) |
| clkEnOut | output | 1 | Generated clock-enable pulse |

## Verification
The commit of a pending update and a fresh software update request can fall in the same clock cycle. The bench provokes this by writing 1 to the command bit during a cycle in which it also raises a selected tick that reaches the live terminal count. The result is judged at the ports. The command bit must still read 1 after that edge, and a further tick must then clear it.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CMD = 3'd0,
    ADDR_CFG = 3'd1,
    ADDR_M   = 3'd2,
    ADDR_N   = 3'd3,
    ADDR_D   = 3'd4
  } regAddr_e;

  // configuration word layout
  localparam int CFG_W    = 14;
  localparam int DIV_LSB  = 0;
  localparam int DIV_W    = 5;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 3;
  localparam int MODE_LSB = 12;
  localparam int MODE_W   = 2;
  localparam logic [MODE_W-1:0] MODE_COUNTER = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/rcg_ctrl.sv
module rcg_ctrl
  import rcg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic                 termCount,
  output ctrlStrobe_t          strobe,
  output logic [DIV_W-1:0]     stageDiv,
  output logic [SEL_W-1:0]     stageSel,
  output logic [MODE_W-1:0]    stageMode,
  output logic [CNT_W-1:0]     stageM,
  output logic [CNT_W-1:0]     stageN
);
  logic [CFG_W-1:0] shadowCfg;
  logic [CNT_W-1:0] shadowM, shadowN, shadowD;
  logic             pending;
  logic             cmdSet;

  assign cmdSet = regWe && (regAddr == ADDR_CMD) && regWdata[0];
  assign strobe.commit = pending && termCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowCfg <= '0;
      shadowM   <= '0;
      shadowN   <= '0;
      shadowD   <= '0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_CFG: shadowCfg <= regWdata[CFG_W-1:0];
        ADDR_M:   shadowM   <= regWdata[CNT_W-1:0];
        ADDR_N:   shadowN   <= regWdata[CNT_W-1:0];
        ADDR_D:   shadowD   <= regWdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  // a new request beats a coincident commit
  always_ff @(posedge clk) begin
    if (rst)                pending <= 1'b0;
    else if (cmdSet)        pending <= 1'b1;
    else if (strobe.commit) pending <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CMD: regRdata[0]           = pending;
      ADDR_CFG: regRdata[CFG_W-1:0]   = shadowCfg;
      ADDR_M:   regRdata[CNT_W-1:0]   = shadowM;
      ADDR_N:   regRdata[CNT_W-1:0]   = shadowN;
      ADDR_D:   regRdata[CNT_W-1:0]   = shadowD;
      default:  regRdata = '0;
    endcase
  end

  assign stageDiv  = shadowCfg[DIV_LSB +: DIV_W];
  assign stageSel  = shadowCfg[SEL_LSB +: SEL_W];
  assign stageMode = shadowCfg[MODE_LSB +: MODE_W];
  assign stageM    = shadowM;
  assign stageN    = shadowN;

  // R9: a commit without a coincident request leaves nothing pending
  assert_commit_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.commit && !cmdSet) |=> !pending);

  // R8: pending only rises after a request write
  assert_pending_needs_request_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(cmdSet));

  // R2: reset leaves no update pending
  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> !pending);
endmodule

// File: rtl/rcg_datapath.sv
module rcg_datapath
  import rcg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcEn,
  input  ctrlStrobe_t        strobe,
  input  logic [DIV_W-1:0]   stageDiv,
  input  logic [SEL_W-1:0]   stageSel,
  input  logic [MODE_W-1:0]  stageMode,
  input  logic [CNT_W-1:0]   stageM,
  input  logic [CNT_W-1:0]   stageN,
  output logic               termCount,
  output logic               clkEnOut
);
  localparam int SEL_SPAN = 1 << SEL_W;

  logic [DIV_W-1:0]    liveDiv;
  logic [SEL_W-1:0]    liveSel;
  logic [MODE_W-1:0]   liveMode;
  logic [CNT_W-1:0]    liveM, liveN;
  logic [SEL_SPAN-1:0] srcPad;
  logic                selEn;
  logic [DIV_W:0]      ratioWide;
  logic [DIV_W-1:0]    ratioM1;
  logic [DIV_W-1:0]    divCnt;
  logic                mnActive;
  logic [CNT_W-1:0]    effN, acc;
  logic [CNT_W:0]      sum;
  logic                wrap;

  // live copy, loaded only on commit
  always_ff @(posedge clk) begin
    if (rst) begin
      liveDiv  <= '0;
      liveSel  <= '0;
      liveMode <= '0;
      liveM    <= '0;
      liveN    <= '0;
    end else if (strobe.commit) begin
      liveDiv  <= stageDiv;
      liveSel  <= stageSel;
      liveMode <= stageMode;
      liveM    <= stageM;
      liveN    <= stageN;
    end
  end

  // source select: pad to the full select range, missing sources read low
  generate
    if (NUM_SRC < SEL_SPAN) begin : gPad
      assign srcPad = {{(SEL_SPAN-NUM_SRC){1'b0}}, srcEn};
    end else begin : gFull
      assign srcPad = srcEn[SEL_SPAN-1:0];
    end
  endgenerate
  assign selEn = srcPad[liveSel];

  // pre-divider: ratio (f+1)/2, f==0 is bypass
  assign ratioWide = ({1'b0, liveDiv} + 1'b1) >> 1;
  assign ratioM1   = (liveDiv == '0) ? '0 : (ratioWide[DIV_W-1:0] - 1'b1);
  assign termCount = selEn && (divCnt == ratioM1);

  always_ff @(posedge clk) begin
    if (rst || strobe.commit) divCnt <= '0;
    else if (selEn)           divCnt <= termCount ? '0 : divCnt + 1'b1;
  end

  // M/N accumulator
  assign mnActive = (liveN != '0) && (liveMode == MODE_COUNTER);
  assign effN     = ~liveN + liveM;
  assign sum      = {1'b0, acc} + {1'b0, liveM};
  assign wrap     = (sum >= {1'b0, effN});

  always_ff @(posedge clk) begin
    if (rst || strobe.commit)      acc <= '0;
    else if (termCount && mnActive) begin
      if (wrap) acc <= CNT_W'(sum - {1'b0, effN});
      else      acc <= sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clkEnOut <= 1'b0;
    else     clkEnOut <= termCount && (!mnActive || wrap);
  end

  // R11: every output pulse follows a selected tick
  assert_out_follows_tick_R11: assert property (@(posedge clk) disable iff (rst)
    clkEnOut |-> $past(selEn));

  // R11: no back-to-back pulses when dividing
  assert_no_back_to_back_R11: assert property (@(posedge clk) disable iff (rst)
    (clkEnOut && (ratioM1 != '0)) |=> !clkEnOut);

  // R5: accumulator stays below the effective N
  assert_acc_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    (mnActive && (effN != '0)) |-> (acc < effN));

  // R9: counter restarts after a commit
  assert_restart_on_commit_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.commit |=> (divCnt == '0) && (acc == '0));
endmodule

// File: rtl/root_clk_gen.sv
module root_clk_gen
  import rcg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               clkEnOut
);
  ctrlStrobe_t       strobe;
  logic              termCount;
  logic [DIV_W-1:0]  stageDiv;
  logic [SEL_W-1:0]  stageSel;
  logic [MODE_W-1:0] stageMode;
  logic [CNT_W-1:0]  stageM, stageN;

  rcg_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .termCount(termCount), .strobe(strobe),
    .stageDiv(stageDiv), .stageSel(stageSel), .stageMode(stageMode),
    .stageM(stageM), .stageN(stageN)
  );

  rcg_datapath #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .srcEn(srcEn), .strobe(strobe),
    .stageDiv(stageDiv), .stageSel(stageSel), .stageMode(stageMode),
    .stageM(stageM), .stageN(stageN),
    .termCount(termCount), .clkEnOut(clkEnOut)
  );
endmodule

// File: tb/root_clk_gen_tb_top.sv
module root_clk_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam logic [NSRC-1:0] ALL = '1;
  localparam int WIN = 24;
  localparam int NVEC = 7;
  localparam int VEC_SRC  [NVEC] = '{0, 1, 2, 3, 1, 0, 2};
  localparam int VEC_DIV  [NVEC] = '{0, 3, 5, 0, 1, 7, 31};
  localparam int VEC_M    [NVEC] = '{0, 0, 1, 3, 2, 3, 0};
  localparam int VEC_N    [NVEC] = '{0, 0, 2, 8, 3, 4, 0};
  localparam int VEC_MODE [NVEC] = '{0, 0, 2, 2, 2, 0, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] srcEn = '0;
  logic [2:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic clkEnOut;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  root_clk_gen #(.NUM_SRC(NSRC)) dut_i (
    .clk(clk), .rst(rst), .srcEn(srcEn), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .clkEnOut(clkEnOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; srcEn = '0; regWe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic pulseAll();
    @(negedge clk); srcEn = ALL;
    @(negedge clk); srcEn = '0;
  endtask

  // request update and tick all sources until the bit clears
  task automatic commitNow(input string req);
    logic [31:0] d;
    bit ok = 0;
    writeReg(3'd0, 32'h1);
    for (int i = 0; i < 40; i++) begin
      readReg(3'd0, d);
      if (d[0] == 1'b0) begin ok = 1; break; end
      pulseAll();
    end
    check(req, 32'(ok), 32'd1);
  endtask

  task automatic runWindow(input int sel, output int cnt);
    cnt = 0;
    for (int c = 0; c < 3*WIN + 4; c++) begin
      @(negedge clk);
      if (clkEnOut) cnt++;
      srcEn = (c < WIN) ? ALL : (ALL & ~(NSRC'(1) << sel));
    end
    srcEn = '0;
  endtask

  function automatic int expectPulses(int f, int m, int n, int mode, int t);
    int ratio = (f == 0) ? 1 : (f + 1) / 2;
    int pre = t / ratio;
    if (n != 0 && mode == 2) return (pre * m) / n;
    return pre;
  endfunction

  function automatic logic [31:0] nRegOf(int m, int n);
    if (n == 0) return 32'h0;
    return 32'(~16'(n - m));
  endfunction

  task automatic configure(int src, int f, int m, int n, int mode);
    writeReg(3'd1, 32'((mode << 12) | (src << 8) | f));
    writeReg(3'd2, 32'(m));
    writeReg(3'd3, nRegOf(m, n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cnt;
    doReset();

    // R2 reset state
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), d); check("R2 reset register", d, 32'h0);
    end
    check("R2 reset output", 32'(clkEnOut), 32'h0);

    // R1 register map and masking
    writeReg(3'd1, 32'hFFFF_FFFF); readReg(3'd1, d); check("R1 cfg mask", d, 32'h3FFF);
    writeReg(3'd2, 32'h1234_ABCD); readReg(3'd2, d); check("R1 M mask", d, 32'hABCD);
    writeReg(3'd4, 32'hDEAD_5A5A); readReg(3'd4, d); check("R1 D readback", d, 32'h5A5A);
    writeReg(3'd3, 32'h0F0F_1357); readReg(3'd3, d); check("R1 N readback", d, 32'h1357);
    writeReg(3'd6, 32'hFFFF_FFFF);
    for (int a = 5; a < 8; a++) begin
      readReg(3'(a), d); check("R1 unmapped", d, 32'h0);
    end
    // R7 staged only: bypass live, output follows every source0 tick
    runWindow(0, cnt); check("R7 staged writes inert", 32'(cnt), 32'(WIN));
    doReset();

    // R3 R4 R5 R6 vector table
    for (int v = 0; v < NVEC; v++) begin
      configure(VEC_SRC[v], VEC_DIV[v], VEC_M[v], VEC_N[v], VEC_MODE[v]);
      commitNow("R9 vector commit");
      runWindow(VEC_SRC[v], cnt);
      check($sformatf("R3/R4/R5/R6 vector %0d", v), 32'(cnt),
            32'(expectPulses(VEC_DIV[v], VEC_M[v], VEC_N[v], VEC_MODE[v], WIN)));
    end

    // R7 staged change without update
    configure(1, 3, 0, 0, 0); commitNow("R9 setup");
    writeReg(3'd1, 32'h0000_0100);
    runWindow(1, cnt); check("R7 no effect before update", 32'(cnt), 32'(WIN/2));
    commitNow("R9 staged commit");
    runWindow(1, cnt); check("R7 effect after update", 32'(cnt), 32'(WIN));

    // R9 commit only at terminal count (ratio 4)
    configure(1, 7, 0, 0, 0); commitNow("R9 setup ratio4");
    writeReg(3'd0, 32'h1);
    repeat (3) pulseAll();
    readReg(3'd0, d); check("R9 held before terminal", d, 32'h1);
    pulseAll();
    readReg(3'd0, d); check("R9 commit at terminal", d, 32'h0);

    // R8 R10 writes while pending, write 0 ignored
    writeReg(3'd1, 32'h0000_2000);
    writeReg(3'd2, 32'h1);
    writeReg(3'd3, nRegOf(1, 4));
    writeReg(3'd0, 32'h1);
    writeReg(3'd2, 32'h3);
    writeReg(3'd0, 32'h0);
    readReg(3'd0, d); check("R8 write 0 keeps pending", d, 32'h1);
    for (int i = 0; i < 4 && d[0]; i++) begin pulseAll(); readReg(3'd0, d); end
    check("R8 poll clears", d, 32'h0);
    runWindow(0, cnt); check("R10 last pending write used", 32'(cnt), 32'(WIN*3/6));

    // R10 request coinciding with commit (live bypass, src0)
    configure(0, 0, 0, 0, 0); commitNow("R9 setup bypass");
    writeReg(3'd0, 32'h1);
    @(negedge clk); regAddr = 3'd0; regWdata = 32'h1; regWe = 1'b1; srcEn = ALL;
    @(negedge clk); regWe = 1'b0; srcEn = '0;
    readReg(3'd0, d); check("R10 coincident request stays", d, 32'h1);
    pulseAll();
    readReg(3'd0, d); check("R10 next terminal commits", d, 32'h0);

    // R11 output timing
    repeat (2) @(negedge clk);
    @(negedge clk); srcEn = 4'b0001; #1;
    check("R11 not same cycle", 32'(clkEnOut), 32'h0);
    @(negedge clk); srcEn = '0;
    check("R11 next cycle", 32'(clkEnOut), 32'h1);
    @(negedge clk);
    check("R11 single pulse", 32'(clkEnOut), 32'h0);

    // R2 reset mid-operation
    writeReg(3'd1, 32'h0000_0105);
    writeReg(3'd0, 32'h1);
    doReset();
    readReg(3'd0, d); check("R2 reset clears pending", d, 32'h0);
    readReg(3'd1, d); check("R2 reset clears cfg", d, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule